// File: doc/BRIEF.md
# Processor Address Decoder with System Registers

This block sorts each bus cycle of a 16-bit processor with a 20-bit address into one of several targets. The targets are fast local RAM, shared system RAM, a trap window that raises an illegal-instruction interrupt, and a small group of system registers just below the top of memory. The RAM selects are combinational, so the memory controllers can start in the same cycle.

The register group has four slots:
- an open-bus slot;
- a write-only multiprocessor control port, which sends reset, interrupt and boot pulses to one of two processors;
- a read-only error syndrome port;
- a read-only parity error address port. Reading it also acknowledges the pending parity interrupt.

Register read data, the trap interrupt and the processor pulses are registered. They appear in the cycle after the access. Each cycle in which a strobe is high counts as one access.

Top module: `pmap_decoder`

## Requirements
- R1: During an access (rd_en or wr_en high) with addr[19:13] all zero and local_dis low, sel_local is high and sel_shared is low in the same cycle. Example: 0x01FFF is local and 0x02000 is shared.
- R2: With local_dis high, an access in the low window raises sel_shared instead of sel_local.
- R3: Any other address outside the special windows raises sel_shared. This includes 0xFFFBF, 0xFFFE0–0xFFFE7 and 0xFFFF0–0xFFFFF. With no strobe, all selects are low.
- R4: A read or write in 0xFFFC0–0xFFFDF raises no select and produces a one-cycle trap_irq pulse in the next cycle. Write data there has no effect.
- R5: A read of 0xFFFE8–0xFFFE9 (open bus) raises sel_io. In the next cycle rd_data is 0xFFFF and rd_drive is low.
- R6: A write to 0xFFFEA–0xFFFEB with a matching target code produces pulses in the next cycle, each lasting one cycle. Data bit 6 drives proc_reset, bit 5 drives proc_irq and bit 4 drives proc_boot, all for that target only.
- R7: The target code in data bits 3..0 maps 0010 to processor index 0 and 0111 to processor index 1. Every other code produces no pulse.
- R8: A read of 0xFFFEC–0xFFFED gives, in the next cycle, rd_drive high and rd_data = {0, parity_bit, syndrome[5:0], fail_addr_hi[7:0]}. These are the input values sampled in the read cycle.
- R9: A read of 0xFFFEE–0xFFFEF gives, in the next cycle, rd_drive high, rd_data = {err_row, err_col}, and a one-cycle parity_ack pulse.
- R10: Writes to the two read-only ports produce no parity_ack, no pulse and no rd_drive. A read of the control port returns 0xFFFF with rd_drive low.
- R11: After reset, all pulses and rd_drive are low and rd_data is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | Bus cycle address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| local_dis | input | 1 | Sends the low window to shared RAM |
| parity_bit | input | 1 | Latched parity bit |
| syndrome | input | 6 | Latched error syndrome |
| fail_addr_hi | input | 8 | Upper address bits of the failing access |
| err_row | input | 8 | Row of the parity error |
| err_col | input | 8 | Column of the parity error |
| sel_local | output | 1 | Local fast RAM select |
| sel_shared | output | 1 | Shared system RAM select |
| sel_io | output | 1 | Register group select |
| rd_data | output | 16 | Register read data |
| rd_drive | output | 1 | rd_data holds valid register data |
| trap_irq | output | 1 | Illegal-instruction interrupt pulse |
| proc_reset | output | 2 | Reset pulse per processor |
| proc_irq | output | 2 | Interrupt pulse per processor |
| proc_boot | output | 2 | Boot pulse per processor |
| parity_ack | output | 1 | Parity interrupt acknowledge pulse |

## Verification
The hardest case to show from the ports is that a control-port write reaches only the addressed processor, lasts exactly one cycle, and does nothing for an unlisted code. The stimulus sends control words that set several request bits together under each valid code, under a near-miss code, and under a code paired with a different bit. It then checks both processors' lines in the pulse cycle and in the cycle after. The syndrome read is checked with the latched inputs changed right after the read cycle, to show that the captured value belongs to the read cycle.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
    localparam int DATA_W = 16;
    localparam int SYN_W  = 6;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_LOCAL,
        RG_SHARED,
        RG_TRAP,
        RG_OPEN,
        RG_CTRL,
        RG_SYND,
        RG_ERRA
    } region_e;
endpackage

// File: rtl/pmap_region.sv
module pmap_region
    import pmap_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int LOCAL_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              local_dis,
    output region_e           region
);
    localparam int TOP_LO = 6;

    logic top_ones;
    logic low_zero;

    always_comb begin
        top_ones = &addr[ADDR_W-1:TOP_LO];
        low_zero = (addr[ADDR_W-1:LOCAL_W] == '0);
        region   = RG_NONE;
        if (rd_en || wr_en) begin
            if (top_ones && !addr[5]) begin
                region = RG_TRAP;
            end else if (top_ones && addr[5] && addr[4:3] == 2'b01) begin
                case (addr[2:1])
                    2'd0:    region = RG_OPEN;
                    2'd1:    region = RG_CTRL;
                    2'd2:    region = RG_SYND;
                    default: region = RG_ERRA;
                endcase
            end else if (low_zero) begin
                region = local_dis ? RG_SHARED : RG_LOCAL;
            end else begin
                region = RG_SHARED;
            end
        end
    end
endmodule

// File: rtl/pmap_ctrl.sv
module pmap_ctrl
    import pmap_pkg::*;
#(
    parameter int                    NPROC  = 2,
    parameter int                    CODE_W = 4,
    parameter logic [NPROC*CODE_W-1:0] CODES = {4'b0111, 4'b0010}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NPROC-1:0]  proc_reset,
    output logic [NPROC-1:0]  proc_irq,
    output logic [NPROC-1:0]  proc_boot,
    output logic              trap_irq
);
    localparam int BIT_RST  = 6;
    localparam int BIT_IRQ  = 5;
    localparam int BIT_BOOT = 4;

    typedef struct packed {
        logic [NPROC-1:0] rst;
        logic [NPROC-1:0] irq;
        logic [NPROC-1:0] boot;
        logic             trap;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic [NPROC-1:0] hit;
    logic             port_wr;

    assign port_wr = wr_en && (region == RG_CTRL);

    for (genvar g = 0; g < NPROC; g++) begin : g_match
        assign hit[g] = port_wr && (wr_data[CODE_W-1:0] == CODES[g*CODE_W +: CODE_W]);
    end

    always_comb begin
        st_d.rst  = hit & {NPROC{wr_data[BIT_RST]}};
        st_d.irq  = hit & {NPROC{wr_data[BIT_IRQ]}};
        st_d.boot = hit & {NPROC{wr_data[BIT_BOOT]}};
        st_d.trap = (region == RG_TRAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign proc_reset = st_q.rst;
    assign proc_irq   = st_q.irq;
    assign proc_boot  = st_q.boot;
    assign trap_irq   = st_q.trap;

    for (genvar g = 0; g < NPROC; g++) begin : g_chk
        p_reset_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
            proc_reset[g] |-> $past(wr_en && region == RG_CTRL && wr_data[BIT_RST]));
        p_boot_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
            proc_boot[g] |-> $past(wr_en && region == RG_CTRL && wr_data[BIT_BOOT]));
    end

    p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(proc_reset | proc_irq | proc_boot));
    p_trap_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_irq |-> $past(region == RG_TRAP));
endmodule

// File: rtl/pmap_regread.sv
module pmap_regread
    import pmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  region_e           region,
    input  logic              rd_en,
    input  logic              parity_bit,
    input  logic [SYN_W-1:0]  syndrome,
    input  logic [BYTE_W-1:0] fail_addr_hi,
    input  logic [BYTE_W-1:0] err_row,
    input  logic [BYTE_W-1:0] err_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    output logic              parity_ack
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              drive;
        logic              ack;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.data  = '1;
        rd_d.drive = 1'b0;
        rd_d.ack   = 1'b0;
        if (rd_en) begin
            if (region == RG_SYND) begin
                rd_d.data  = {1'b0, parity_bit, syndrome, fail_addr_hi};
                rd_d.drive = 1'b1;
            end else if (region == RG_ERRA) begin
                rd_d.data  = {err_row, err_col};
                rd_d.drive = 1'b1;
                rd_d.ack   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q.data  <= '1;
            rd_q.drive <= 1'b0;
            rd_q.ack   <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data    = rd_q.data;
    assign rd_drive   = rd_q.drive;
    assign parity_ack = rd_q.ack;

    p_ack_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        parity_ack |-> $past(rd_en && region == RG_ERRA));
    p_drive_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> $past(rd_en));
    p_undriven_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> rd_data == '1);
endmodule

// File: rtl/pmap_decoder.sv
module pmap_decoder
    import pmap_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int LOCAL_W = 13,
    parameter int NPROC   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 local_dis,
    input  logic                 parity_bit,
    input  logic [SYN_W-1:0]     syndrome,
    input  logic [BYTE_W-1:0]    fail_addr_hi,
    input  logic [BYTE_W-1:0]    err_row,
    input  logic [BYTE_W-1:0]    err_col,
    output logic                 sel_local,
    output logic                 sel_shared,
    output logic                 sel_io,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_drive,
    output logic                 trap_irq,
    output logic [NPROC-1:0]     proc_reset,
    output logic [NPROC-1:0]     proc_irq,
    output logic [NPROC-1:0]     proc_boot,
    output logic                 parity_ack
);
    region_e region;

    pmap_region #(.ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W)) u_region (
        .addr      (addr),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .local_dis (local_dis),
        .region    (region)
    );

    always_comb begin
        sel_local  = (region == RG_LOCAL);
        sel_shared = (region == RG_SHARED);
        sel_io     = (region == RG_OPEN) || (region == RG_CTRL) ||
                     (region == RG_SYND) || (region == RG_ERRA);
    end

    pmap_ctrl #(.NPROC(NPROC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .region     (region),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .proc_reset (proc_reset),
        .proc_irq   (proc_irq),
        .proc_boot  (proc_boot),
        .trap_irq   (trap_irq)
    );

    pmap_regread u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .region       (region),
        .rd_en        (rd_en),
        .parity_bit   (parity_bit),
        .syndrome     (syndrome),
        .fail_addr_hi (fail_addr_hi),
        .err_row      (err_row),
        .err_col      (err_col),
        .rd_data      (rd_data),
        .rd_drive     (rd_drive),
        .parity_ack   (parity_ack)
    );

    p_sel_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_local, sel_shared, sel_io}));
    p_local_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_local |-> !local_dis);
    p_local_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_local |-> addr[ADDR_W-1:LOCAL_W] == '0);
    p_trap_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_irq |-> $past(rd_en || wr_en));
endmodule

// File: tb/pmap_decoder_test.sv
module pmap_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        local_dis = 1'b0;
    logic        parity_bit = 1'b0;
    logic [5:0]  syndrome = '0;
    logic [7:0]  fail_addr_hi = '0, err_row = '0, err_col = '0;
    logic        sel_local, sel_shared, sel_io, rd_drive, trap_irq, parity_ack;
    logic [15:0] rd_data;
    logic [1:0]  proc_reset, proc_irq, proc_boot;

    int total = 0;
    int failed = 0;
    logic [2:0] c_sel;

    always #2.5 clk = ~clk;

    pmap_decoder uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one access cycle; c_sel holds combinational selects, registered
    // outputs are sampled afterwards by the caller (one cycle later)
    task automatic access(logic [19:0] a, logic r, logic w, logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = r; wr_en = w; wr_data = d;
        #1 c_sel = {sel_local, sel_shared, sel_io};
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        chk("R11 rd_data", rd_data, 16'hFFFF);
        chk("R11 pulses", {rd_drive, trap_irq, parity_ack, proc_reset, proc_irq, proc_boot}, 0);
    endtask

    task automatic t_local();
        local_dis = 1'b0;
        access(20'h01234, 1, 0, 0); chk("R1 mid", c_sel, 3'b100);
        access(20'h01FFF, 0, 1, 0); chk("R1 top", c_sel, 3'b100);
        access(20'h02000, 1, 0, 0); chk("R1 edge", c_sel, 3'b010);
        local_dis = 1'b1;
        access(20'h00010, 1, 0, 0); chk("R2 disabled", c_sel, 3'b010);
        local_dis = 1'b0;
    endtask

    task automatic t_shared();
        access(20'h80000, 0, 1, 0); chk("R3 mid", c_sel, 3'b010);
        access(20'hFFFBF, 1, 0, 0); chk("R3 below trap", c_sel, 3'b010);
        access(20'hFFFE0, 1, 0, 0); chk("R3 FFFE0", c_sel, 3'b010);
        access(20'hFFFF0, 1, 0, 0); chk("R3 FFFF0", c_sel, 3'b010);
        #1 chk("R3 idle", {sel_local, sel_shared, sel_io}, 0);
    endtask

    task automatic t_trap();
        access(20'hFFFC0, 0, 1, 16'h0072);
        chk("R4 no sel", c_sel, 0);
        chk("R4 pulse", trap_irq, 1);
        chk("R4 data ignored", {proc_reset, proc_irq, proc_boot, rd_drive}, 0);
        @(negedge clk); #1 chk("R4 one cycle", trap_irq, 0);
        access(20'hFFFDF, 1, 0, 0);
        chk("R4 read pulse", trap_irq, 1);
    endtask

    task automatic t_open();
        access(20'hFFFE8, 1, 0, 0);
        chk("R5 sel_io", c_sel, 3'b001);
        chk("R5 data", {rd_drive, rd_data}, {1'b0, 16'hFFFF});
    endtask

    task automatic t_ctrl();
        access(20'hFFFEA, 0, 1, 16'h0072);
        chk("R6 proc0 all", {proc_reset, proc_irq, proc_boot}, 6'b01_01_01);
        @(negedge clk); #1 chk("R6 one cycle", {proc_reset, proc_irq, proc_boot}, 0);
        access(20'hFFFEB, 0, 1, 16'h0027);
        chk("R7 proc1 irq", {proc_reset, proc_irq, proc_boot}, 6'b00_10_00);
        access(20'hFFFEA, 0, 1, 16'h0047);
        chk("R7 proc1 reset", {proc_reset, proc_irq, proc_boot}, 6'b10_00_00);
        access(20'hFFFEA, 0, 1, 16'h0073);
        chk("R7 bad code", {proc_reset, proc_irq, proc_boot}, 0);
        access(20'hFFFEA, 0, 1, 16'h0016);
        chk("R7 code 0110", {proc_reset, proc_irq, proc_boot}, 0);
    endtask

    task automatic t_synd();
        parity_bit = 1'b1; syndrome = 6'h2A; fail_addr_hi = 8'h5C;
        @(negedge clk);
        addr = 20'hFFFEC; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; parity_bit = 1'b0; syndrome = 6'h01; fail_addr_hi = 8'h00;
        #1 chk("R8 syndrome word", {rd_drive, rd_data}, {1'b1, 16'h6A5C});
        chk("R8 no ack", parity_ack, 0);
    endtask

    task automatic t_erra();
        err_row = 8'h3C; err_col = 8'hA5;
        access(20'hFFFEE, 1, 0, 0);
        chk("R9 data", {rd_drive, rd_data}, {1'b1, 16'h3CA5});
        chk("R9 ack", parity_ack, 1);
        @(negedge clk); #1 chk("R9 ack one cycle", parity_ack, 0);
    endtask

    task automatic t_ro();
        access(20'hFFFEE, 0, 1, 16'hFFFF);
        chk("R10 write erra", {parity_ack, rd_drive, proc_reset, proc_irq, proc_boot}, 0);
        access(20'hFFFEC, 0, 1, 16'h0072);
        chk("R10 write synd", {parity_ack, rd_drive, proc_reset, proc_irq, proc_boot}, 0);
        access(20'hFFFEA, 1, 0, 0);
        chk("R10 read ctrl", {rd_drive, rd_data, proc_reset}, {1'b0, 16'hFFFF, 2'b00});
    endtask

    initial begin
        #200_000;
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_local();
        t_shared();
        t_trap();
        t_open();
        t_ctrl();
        t_synd();
        t_erra();
        t_ro();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule